// File: doc/BRIEF.md
# Channel-Programmable Pulse-Swallow Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It runs on the oscillator clock and emits one single-cycle pulse every M oscillator cycles for the phase detector. Inside, a dual-modulus prescaler divides by 8 or by 9. A program counter counts 24 prescaler cycles per output period. A swallow counter decides how many of those cycles use the long modulus. The block also drives the modulus-control line. One extra reload cycle per period marks the output pulse. The total ratio is therefore M = 8·24 + S + 1.

A small channel index picks the swallow count as S = 7 + n for n in 1..6, so M = 200 + n. Each channel lands on its own multiple of the comparison frequency for an oscillator running at one third of the carrier. Indices outside the valid range are ignored. A valid index is held as a pending setting and is loaded only when an output period ends, so every period is whole. Reset loads the default channel and restarts all counters together.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is 0 and `mod_ctl` is 1. The first period after reset release uses the default channel 1 (M = 201), so the first `div_pulse` is seen in the 201st cycle counted from the release.
- R2: With a valid channel n (1 to 6) in effect, `div_pulse` repeats every M = 200 + n clock cycles. Here S = 7 + n, and M = 8·24 + S + 1.
- R3: `div_pulse` is high for exactly one clock cycle per period.
- R4: In every period, `mod_ctl` is high for 9·S + 1 cycles. It rises only in the cycle where `div_pulse` is high. While it is high the prescaler counts 9 cycles; while it is low the prescaler counts 8.
- R5: A channel change never alters the period already running. The new setting is loaded at the next `div_pulse`. If the index changes more than once within a period, the last valid value before that boundary wins.
- R6: A `chan_sel` value of 0 or 7 is ignored, and the last valid channel stays in force.
- R7: Asserting `rst_n` mid-period abandons that period and restarts the divider with the default channel. A valid index presented on release applies from the second period on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, one divider input cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset of all counters |
| chan_sel | input | 3 | Channel index; 1 to 6 valid |
| div_pulse | output | 1 | One-cycle pulse per output period, to the phase detector |
| mod_ctl | output | 1 | Modulus control: 1 selects divide-by-9, 0 selects divide-by-8 |

## Verification
The bench builds the block with its default parameters: modulus pair 8/9, program count 24, swallow offset 7 and a 3-bit channel index. With these values every channel from 201 to 206 is reachable, and so are both out-of-range codes 0 and 7. Periods stay short enough that dozens of them fit in one run. The scoreboard checks each period's length and its count of long-modulus cycles. It covers reloads after reset, channel changes at the boundary and mid-period, and rapid re-selection within a period.

// File: rtl/psd_pkg.sv
package psd_pkg;

   typedef enum logic {
      PRE_BINARY = 1'b0,
      PRE_RING   = 1'b1
   } pre_style_e;

   function automatic int unsigned total_ratio(input int unsigned low_mod,
                                               input int unsigned prog,
                                               input int unsigned swal);
      return low_mod * prog + swal + 1;
   endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
   import psd_pkg::*;
#(
   parameter int unsigned PRE_LOW = 8,
   parameter pre_style_e  STYLE   = PRE_BINARY
)(
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic mod_hi_i,
   output logic end_o
);

   generate
      if (STYLE == PRE_BINARY) begin : g_binary
         localparam int unsigned CW = $clog2(PRE_LOW + 1);
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] term;

         assign term  = mod_hi_i ? CW'(PRE_LOW) : CW'(PRE_LOW - 1);
         assign end_o = !hold_i && (cnt_q == term);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (hold_i || end_o)  cnt_q <= '0;
            else                       cnt_q <= cnt_q + CW'(1);
         end

         a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(PRE_LOW));
         a_r4_hold_restart: assert property (@(posedge clk) disable iff (!rst_n)
            hold_i |=> (cnt_q == '0));
      end else begin : g_ring
         logic [PRE_LOW:0] ring_q;

         assign end_o = !hold_i && (mod_hi_i ? ring_q[PRE_LOW] : ring_q[PRE_LOW-1]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                ring_q <= (PRE_LOW+1)'(1);
            else if (hold_i || end_o)  ring_q <= (PRE_LOW+1)'(1);
            else                       ring_q <= ring_q << 1;
         end

         a_r4_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(ring_q) == 1);
         a_r4_hold_restart: assert property (@(posedge clk) disable iff (!rst_n)
            hold_i |=> ring_q[0]);
      end
   endgenerate

endmodule

// File: rtl/psd_frame_ctr.sv
module psd_frame_ctr #(
   parameter int unsigned PROG_CNT = 24,
   parameter int unsigned SWAL_MAX = 20,
   parameter int unsigned SWAL_RST = 8,
   localparam int unsigned PW = $clog2(PROG_CNT + 1),
   localparam int unsigned SW = $clog2(SWAL_MAX + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pre_end_i,
   input  logic          load_i,
   input  logic [SW-1:0] swal_load_i,
   output logic          mod_hi_o,
   output logic          last_o
);

   logic [PW-1:0] prog_q;
   logic [SW-1:0] swal_q;

   assign mod_hi_o = (swal_q != '0);
   assign last_o   = pre_end_i && (prog_q == PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q <= PW'(PROG_CNT);
         swal_q <= SW'(SWAL_RST);
      end else if (load_i) begin
         prog_q <= PW'(PROG_CNT);
         swal_q <= swal_load_i;
      end else if (pre_end_i) begin
         prog_q <= prog_q - PW'(1);
         if (swal_q != '0) swal_q <= swal_q - SW'(1);
      end
   end

   // R2: the program counter never runs out inside a period
   a_r2_prog_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      prog_q != '0);
   // R4: the swallowed cycles always fit inside the remaining program cycles
   a_r4_swal_le_prog: assert property (@(posedge clk) disable iff (!rst_n)
      int'(swal_q) <= int'(prog_q));

endmodule

// File: rtl/psd_chan_map.sv
module psd_chan_map #(
   parameter int unsigned CH_W     = 3,
   parameter int unsigned CH_MIN   = 1,
   parameter int unsigned CH_MAX   = 6,
   parameter int unsigned CH_DEF   = 1,
   parameter int unsigned SWAL_OFS = 7,
   parameter int unsigned SW       = 5
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_W-1:0] chan_i,
   output logic [SW-1:0]   swal_o
);

   logic [CH_W-1:0] pend_q;
   logic            chan_ok;

   assign chan_ok = (chan_i >= CH_W'(CH_MIN)) && (chan_i <= CH_W'(CH_MAX));
   assign swal_o  = SW'(SWAL_OFS) + SW'(pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= CH_W'(CH_DEF);
      else if (chan_ok) pend_q <= chan_i;
   end

   a_r6_pending_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q >= CH_W'(CH_MIN)) && (pend_q <= CH_W'(CH_MAX)));
   a_r6_invalid_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_ok |=> $stable(pend_q));

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
   import psd_pkg::*;
#(
   parameter int unsigned PRE_LOW   = 8,
   parameter int unsigned PROG_CNT  = 24,
   parameter int unsigned SWAL_MIN  = 1,
   parameter int unsigned SWAL_MAX  = 20,
   parameter int unsigned CH_W      = 3,
   parameter int unsigned CH_MIN    = 1,
   parameter int unsigned CH_MAX    = 6,
   parameter int unsigned CH_DEF    = 1,
   parameter int unsigned SWAL_OFS  = 7,
   parameter pre_style_e  PRE_STYLE = PRE_BINARY
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_W-1:0] chan_sel,
   output logic            div_pulse,
   output logic            mod_ctl
);

   localparam int unsigned SW       = $clog2(SWAL_MAX + 1);
   localparam int unsigned SWAL_RST = SWAL_OFS + CH_DEF;
   localparam int unsigned M_RST    = total_ratio(PRE_LOW, PROG_CNT, SWAL_RST);

   initial begin
      assert (PRE_LOW >= 2) else $error("prescaler low modulus too small");
      assert (SWAL_OFS + CH_MIN >= SWAL_MIN) else $error("lowest channel under swallow range");
      assert (SWAL_OFS + CH_MAX <= SWAL_MAX) else $error("highest channel over swallow range");
      assert (SWAL_MAX < PROG_CNT) else $error("swallow range must stay below program count");
      assert (CH_DEF >= CH_MIN && CH_DEF <= CH_MAX) else $error("default channel out of range");
      assert (CH_MAX < 2**CH_W) else $error("channel index too narrow");
      assert (M_RST > PRE_LOW * PROG_CNT) else $error("ratio derivation inconsistent");
   end

   logic          pre_end;
   logic          mod_hi;
   logic          last;
   logic          gap_q;
   logic [SW-1:0] swal_next;

   psd_chan_map #(
      .CH_W(CH_W), .CH_MIN(CH_MIN), .CH_MAX(CH_MAX), .CH_DEF(CH_DEF),
      .SWAL_OFS(SWAL_OFS), .SW(SW)
   ) u_chan (
      .clk(clk), .rst_n(rst_n), .chan_i(chan_sel), .swal_o(swal_next)
   );

   psd_prescaler #(.PRE_LOW(PRE_LOW), .STYLE(PRE_STYLE)) u_pre (
      .clk(clk), .rst_n(rst_n), .hold_i(gap_q), .mod_hi_i(mod_hi), .end_o(pre_end)
   );

   psd_frame_ctr #(.PROG_CNT(PROG_CNT), .SWAL_MAX(SWAL_MAX), .SWAL_RST(SWAL_RST)) u_frame (
      .clk(clk), .rst_n(rst_n), .pre_end_i(pre_end), .load_i(last),
      .swal_load_i(swal_next), .mod_hi_o(mod_hi), .last_o(last)
   );

   // reload cycle: counters were loaded on entry, prescaler is held for one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_q <= 1'b0;
      else        gap_q <= last;
   end

   assign div_pulse = gap_q;
   assign mod_ctl   = mod_hi;

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);
   a_r4_mc_high_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> mod_ctl);
   a_r4_mc_rise_only_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_ctl) |-> div_pulse);
   a_r5_no_prescale_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> !pre_end);

endmodule

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] chan_sel = 3'd1;
   logic       div_pulse;
   logic       mod_ctl;

   pulse_swallow_div dut (
      .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel),
      .div_pulse(div_pulse), .mod_ctl(mod_ctl)
   );

   always #4 clk = ~clk;

   typedef struct {
      int    m;
      string req;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   int   pend_m   = 201;
   int   cnt      = 0;
   int   mc_cnt   = 0;
   bit   prev_p   = 1'b0;
   bit   done     = 1'b0;
   exp_t e;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp_v);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
      end
   endtask

   // monitor: counts cycles per period and compares against the queue
   always @(negedge clk) begin
      if (!rst_n) begin
         cnt = 0; mc_cnt = 0; prev_p = 1'b0;
      end else begin
         cnt++;
         if (mod_ctl) mc_cnt++;
         if (div_pulse) begin
            check(!prev_p, "R3", "pulse width", 2, 1);
            if (q.size() == 0) begin
               check(1'b0, "R2", "unexpected pulse at cycle", cnt, 0);
            end else begin
               e = q.pop_front();
               check(cnt == e.m, e.req, "period", cnt, e.m);
               check(mc_cnt == 9 * (e.m - 8 * 24 - 1) + 1, "R4", "mod_ctl high cycles",
                     mc_cnt, 9 * (e.m - 8 * 24 - 1) + 1);
            end
            cnt = 0; mc_cnt = 0;
         end
         prev_p = div_pulse;
      end
   end

   task automatic set_ch(input int ch);
      chan_sel = 3'(ch);
      if (ch >= 1 && ch <= 6) pend_m = 200 + ch;
   endtask

   task automatic set_ch_mid(input int ch);
      if (q.size() > 0) q[q.size()-1].req = "R5";
      set_ch(ch);
   endtask

   task automatic wait_pulse(input string req);
      exp_t it;
      do begin
         @(posedge clk); #1;
      end while (!div_pulse);
      it.m = pend_m; it.req = req;
      q.push_back(it);
   endtask

   task automatic do_reset(input int ch, input string req);
      exp_t it;
      @(posedge clk); #1;
      rst_n = 1'b0;
      chan_sel = 3'(ch);
      q.delete();
      repeat (3) @(posedge clk);
      #1;
      check(div_pulse == 1'b0, "R1", "div_pulse in reset", int'(div_pulse), 0);
      check(mod_ctl == 1'b1, "R1", "mod_ctl in reset", int'(mod_ctl), 1);
      rst_n = 1'b1;
      it.m = 201; it.req = req;
      q.push_back(it);
      pend_m = (ch >= 1 && ch <= 6) ? 200 + ch : 201;
   endtask

   initial begin
      do_reset(1, "R1");
      wait_pulse("R2");
      for (int ch = 2; ch <= 6; ch++) begin
         set_ch(ch);
         wait_pulse("R2");
         wait_pulse("R2");
      end
      // mid-period change: running period keeps 206
      repeat (40) @(posedge clk);
      #1 set_ch_mid(3);
      wait_pulse("R5");
      wait_pulse("R5");
      // out-of-range codes are ignored
      set_ch(0);
      wait_pulse("R6");
      repeat (60) @(posedge clk);
      #1 set_ch(7);
      wait_pulse("R6");
      wait_pulse("R6");
      // several selections within one period: last valid wins
      repeat (30) @(posedge clk);
      #1 set_ch_mid(5);
      repeat (20) @(posedge clk);
      #1 set_ch(7);
      repeat (20) @(posedge clk);
      #1 set_ch(2);
      wait_pulse("R5");
      wait_pulse("R5");
      // reset in the middle of a period
      repeat (77) @(posedge clk);
      do_reset(6, "R7");
      wait_pulse("R7");
      wait_pulse("R7");
      // drain the last queued period
      do begin
         @(posedge clk); #1;
      end while (!div_pulse);
      @(posedge clk); #1;
      check(q.size() == 0, "R2", "scoreboard left over", q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule